// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers every interrupt source of a graphics processor core and turns them into a single request toward the instruction sequencer. Seven maskable sources feed it: two external request pins, a host request bit, a display-line match, a pixel-window violation, a bus fault and a single-step request. Each source sets its own sticky pending flag on a low-to-high transition. A pending flag is forwarded to the CPU only while the matching enable bit is set. When several flags are eligible, a fixed priority picks one, and the block reports that source's identifier.

A host-controlled non-maskable request sits above all of them and ignores the enable register. A companion mode bit is captured together with it and decides whether the CPU should push its state when it takes the request. The host can therefore interrupt the core before a stack pointer has been set up. A small register port gives access to the enable bits, the pending bits, the line number that the display comparator looks for, and the window polarity.

Top module: `irq_hub`

## Requirements
- R1: After synchronous reset (rst_n low at a rising clock edge) the enable bits, pending bits, line-compare value and window mode read back as 0 and irq_req is 0. An input that is already high when reset is released does not count as an event.
- R2: Each source sets its pending bit only on a 0-to-1 transition of its event. A level held high does not set the bit again after it has been cleared. External pin 1 sets bit 0 and external pin 2 sets bit 1.
- R3: irq_req is 1 only when the non-maskable request is pending or at least one pending bit has its enable bit set. Enable register: address 0, bits 6:0, laid out the same way as the pending bits.
- R4: A window event is a cycle with pix_wr high and pix_in_win equal to the window-mode bit. The window-mode bit is bit 0 at address 3: 0 flags writes outside the window and 1 flags writes inside it. A window event sets pending bit 4.
- R5: A rising host_irq sets pending bit 2.
- R6: A display event sets pending bit 3. It occurs when line_now becomes equal to the line-compare value held at address 2, bits LW-1:0.
- R7: A rising bus_fault sets pending bit 5 and a rising step_req sets pending bit 6.
- R8: Among the pending bits that are also enabled, the lowest bit index wins. irq_src carries that bit index (0 = external 1 through 6 = single-step).
- R9: A rising host_nmi raises a non-maskable request whatever the enable bits are. This request has priority over every maskable source and is reported as irq_src = 7.
- R10: irq_save is the inverse of nmi_nosave as captured on the host_nmi rising edge while the non-maskable request is being reported. It is 1 while a maskable source is reported.
- R11: Writing address 1 clears every pending bit whose write-data bit is 0 and leaves the bits written as 1 unchanged. Reading address 1 returns the pending bits in 6:0.
- R12: irq_ack with irq_src = 7 clears the non-maskable request. irq_ack while a maskable source is reported leaves its pending bit set.
- R13: When an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_irq1 | input | 1 | External request pin 1 |
| ext_irq2 | input | 1 | External request pin 2 |
| host_irq | input | 1 | Host interrupt-request control bit |
| pix_wr | input | 1 | Pixel write strobe |
| pix_in_win | input | 1 | Current pixel write lies inside the window |
| line_now | input | LW | Line currently being displayed |
| bus_fault | input | 1 | Bus fault event |
| step_req | input | 1 | Single-step event |
| host_nmi | input | 1 | Host non-maskable request bit |
| nmi_nosave | input | 1 | Mode bit: 1 means do not save processor state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq_ack | input | 1 | CPU acknowledge of the reported request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_src | output | 3 | Identifier of the reported source |
| irq_save | output | 1 | CPU should save state when taking the request |

## Verification
Every stored flag is visible at the ports one clock after it changes. A pending or enable bit that is corrupted shows up on the next register read, and on irq_req and irq_src in the same cycle if the bit is enabled. An edge detector stuck at the wrong polarity either misses a one-cycle pulse or fires again on a held level. The held-level and same-cycle clear tests expose either fault within two clocks. A lost non-maskable flag or mode capture shows up as a wrong irq_src or irq_save in the cycle right after the host edge, and a missing clear shows up in the cycle after acknowledge.

// File: rtl/irq_pkg.sv
// Shared constants for the interrupt request controller.
// Assumes seven maskable sources; the non-maskable source takes the id
// right after the last maskable one.
package irq_pkg;
    localparam int NSRC  = 7;
    localparam int SRC_W = $clog2(NSRC + 1);
    localparam logic [SRC_W-1:0] NMI_ID = SRC_W'(NSRC);

    // Bit positions of the maskable sources; the lower index has higher priority.
    localparam int SB_EXT1 = 0;
    localparam int SB_EXT2 = 1;
    localparam int SB_HOST = 2;
    localparam int SB_LINE = 3;
    localparam int SB_WIN  = 4;
    localparam int SB_BUS  = 5;
    localparam int SB_STEP = 6;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_PEND   = 2'd1,
        RA_LINE   = 2'd2,
        RA_WMODE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_edge.sv
// Rising-edge detector for a vector of event signals.
// Assumes synchronous inputs. The history resets to all ones, so a level
// that is already high when reset ends does not count as an event.
module irq_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Keep last cycle's value of every event.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;

    // A reported edge requires the input to have been low one cycle earlier.
    p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & $past(sig)) == '0);
endmodule

// File: rtl/irq_pend_bank.sv
// Register bank: enable bits, sticky pending bits, line-compare value and
// window mode, with a combinational read mux.
// Assumes DW is at least NSRC and LW. On a pending bit, a new event
// overrides a clearing write in the same cycle.
module irq_pend_bank
    import irq_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NSRC-1:0] rise,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] pend_q,
    output logic [LW-1:0]   line_cmp_q,
    output logic            win_mode_q
);
    logic [NSRC-1:0] clr_mask;
    logic            wr_en, wr_pend, wr_line, wr_mode;
    logic            unused_wbits;

    assign unused_wbits = ^reg_wdata;

    // Decode which register a write targets.
    always_comb begin
        wr_en   = reg_wr && (reg_addr == RA_ENABLE);
        wr_pend = reg_wr && (reg_addr == RA_PEND);
        wr_line = reg_wr && (reg_addr == RA_LINE);
        wr_mode = reg_wr && (reg_addr == RA_WMODE);
        clr_mask = wr_pend ? ~reg_wdata[NSRC-1:0] : '0;
    end

    // Enable bits, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= reg_wdata[NSRC-1:0];
    end

    // Pending bits: write-zero-to-clear, events set with precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | rise;
    end

    // Display line the comparator looks for.
    always_ff @(posedge clk) begin
        if (!rst_n)       line_cmp_q <= '0;
        else if (wr_line) line_cmp_q <= reg_wdata[LW-1:0];
    end

    // Window polarity: 0 flags outside writes, 1 flags inside writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       win_mode_q <= 1'b0;
        else if (wr_mode) win_mode_q <= reg_wdata[0];
    end

    // Read multiplexer.
    always_comb begin
        unique case (reg_addr)
            RA_ENABLE: reg_rdata = DW'(en_q);
            RA_PEND:   reg_rdata = DW'(pend_q);
            RA_LINE:   reg_rdata = DW'(line_cmp_q);
            default:   reg_rdata = DW'(win_mode_q);
        endcase
    end

    // Every event shows as pending on the next cycle, even during a clear.
    p_event_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

    // After a pending write, zero-written bits are clear unless an event set them.
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & ~$past(reg_wdata[NSRC-1:0]) & ~$past(rise)) == '0));
endmodule

// File: rtl/irq_prio.sv
// Fixed-priority selector: the lowest set request index wins.
// Assumes N fits within SRC_W bits of index.
module irq_prio #(
    parameter int N     = 7,
    parameter int SRC_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [SRC_W-1:0] idx
);
    logic [N-1:0] grant;

    // Scan from the top down so the lowest index is assigned last.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = SRC_W'(i);
            end
        end
        any = |req;
    end

    // At most one grant, and only when some request exists.
    always_comb begin
        a_grant_onehot_r8: assert ($onehot0(grant) && ((|grant) == (|req)));
    end
endmodule

// File: rtl/irq_hub.sv
// Interrupt request controller top. It derives the window and display events,
// edge-detects all sources, keeps the mask and pending registers and the
// non-maskable request, and reports one source to the CPU.
// Assumes every input is synchronous to clk.
module irq_hub
    import irq_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_irq1,
    input  logic             ext_irq2,
    input  logic             host_irq,
    input  logic             pix_wr,
    input  logic             pix_in_win,
    input  logic [LW-1:0]    line_now,
    input  logic             bus_fault,
    input  logic             step_req,
    input  logic             host_nmi,
    input  logic             nmi_nosave,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [SRC_W-1:0] irq_src,
    output logic             irq_save
);
    logic [NSRC:0]      ev, rise;
    logic [NSRC-1:0]    en_q, pend_q;
    logic [LW-1:0]      line_cmp_q;
    logic               win_mode_q;
    logic               win_ev, line_hit;
    logic               m_any;
    logic [SRC_W-1:0]   m_idx;
    logic               nmi_pend_q, nmi_save_q;

    // Event levels for the derived sources.
    always_comb begin
        win_ev   = pix_wr && (pix_in_win == win_mode_q);
        line_hit = (line_now == line_cmp_q);
    end

    // Assemble the event vector in priority order; the top bit is the non-maskable request.
    always_comb begin
        ev          = '0;
        ev[SB_EXT1] = ext_irq1;
        ev[SB_EXT2] = ext_irq2;
        ev[SB_HOST] = host_irq;
        ev[SB_LINE] = line_hit;
        ev[SB_WIN]  = win_ev;
        ev[SB_BUS]  = bus_fault;
        ev[SB_STEP] = step_req;
        ev[NSRC]    = host_nmi;
    end

    irq_edge #(.W(NSRC + 1)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (ev),
        .rise (rise)
    );

    irq_pend_bank #(.DW(DW), .LW(LW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rise      (rise[NSRC-1:0]),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .line_cmp_q(line_cmp_q),
        .win_mode_q(win_mode_q)
    );

    irq_prio #(.N(NSRC), .SRC_W(SRC_W)) u_prio (
        .req(pend_q & en_q),
        .any(m_any),
        .idx(m_idx)
    );

    // Non-maskable request with its captured save mode; a new edge beats an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_pend_q <= 1'b0;
            nmi_save_q <= 1'b0;
        end else if (rise[NSRC]) begin
            nmi_pend_q <= 1'b1;
            nmi_save_q <= ~nmi_nosave;
        end else if (irq_ack && nmi_pend_q) begin
            nmi_pend_q <= 1'b0;
        end
    end

    // Output selection: the non-maskable request first, then the maskable winner.
    always_comb begin
        irq_req  = nmi_pend_q || m_any;
        irq_src  = nmi_pend_q ? NMI_ID : (m_any ? m_idx : '0);
        irq_save = nmi_pend_q ? nmi_save_q : m_any;
    end

    // With nothing enabled and pending, no request leaves the block.
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_pend_q && ((pend_q & en_q) == '0)) |-> !irq_req);

    // The non-maskable request overrides every maskable source.
    p_nmi_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend_q |-> (irq_req && (irq_src == NMI_ID)));

    // The non-maskable request stays until it is acknowledged.
    p_nmi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_q && !irq_ack) |=> nmi_pend_q);

    // Maskable sources always ask for a state save.
    p_save_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (irq_src != NMI_ID)) |-> irq_save);
endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    localparam int DW = 16;
    localparam int LW = 11;
    localparam int NV = 12;
    localparam logic [LW-1:0] CMP_LINE = LW'(5);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_irq1 = 0, ext_irq2 = 0, host_irq = 0, pix_wr = 0, pix_in_win = 0;
    logic [LW-1:0] line_now = '0;
    logic bus_fault = 0, step_req = 0, host_nmi = 0, nmi_nosave = 0;
    logic reg_wr = 0;
    logic [1:0] reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic irq_ack = 0;
    logic irq_req;
    logic [2:0] irq_src;
    logic irq_save;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic wmode = 1'b0;

    always #4 clk = ~clk;

    irq_hub #(.DW(DW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_irq1(ext_irq1), .ext_irq2(ext_irq2),
        .host_irq(host_irq), .pix_wr(pix_wr), .pix_in_win(pix_in_win),
        .line_now(line_now), .bus_fault(bus_fault), .step_req(step_req),
        .host_nmi(host_nmi), .nmi_nosave(nmi_nosave), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_src(irq_src), .irq_save(irq_save)
    );

    // Vector: {enable[6:0], pulsed sources[6:0], expected req, expected src[2:0]}
    localparam logic [17:0] VEC [NV] = '{
        {7'h7f, 7'h01, 1'b1, 3'd0},
        {7'h7f, 7'h02, 1'b1, 3'd1},
        {7'h7f, 7'h04, 1'b1, 3'd2},
        {7'h7f, 7'h08, 1'b1, 3'd3},
        {7'h7f, 7'h10, 1'b1, 3'd4},
        {7'h7f, 7'h20, 1'b1, 3'd5},
        {7'h7f, 7'h40, 1'b1, 3'd6},
        {7'h00, 7'h7f, 1'b0, 3'd0},
        {7'h7e, 7'h7f, 1'b1, 3'd1},
        {7'h60, 7'h7f, 1'b1, 3'd5},
        {7'h7f, 7'h50, 1'b1, 3'd4},
        {7'h08, 7'h0c, 1'b1, 3'd3}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic [6:0] m);
        ext_irq1   = m[0];
        ext_irq2   = m[1];
        host_irq   = m[2];
        line_now   = m[3] ? CMP_LINE : '0;
        pix_wr     = m[4];
        pix_in_win = wmode;
        bus_fault  = m[5];
        step_req   = m[6];
    endtask

    task automatic pulse(input logic [6:0] m);
        @(negedge clk);
        drive(m);
        @(negedge clk);
        drive(7'h00);
        @(negedge clk);
    endtask

    task automatic nmi_pulse(input logic nosave);
        @(negedge clk);
        host_nmi = 1'b1; nmi_nosave = nosave;
        @(negedge clk);
        host_nmi = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state (line_now equals the reset compare value: no event)
        check("R1 irq_req", irq_req, 0);
        rd(2'd0, d); check("R1 enable", d, 0);
        rd(2'd1, d); check("R1 pending", d, 0);
        rd(2'd2, d); check("R1 line", d, 0);
        rd(2'd3, d); check("R1 wmode", d, 0);

        wr(2'd2, DW'(CMP_LINE));

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, '0);
            wr(2'd0, DW'(VEC[i][17:11]));
            pulse(VEC[i][10:4]);
            check($sformatf("R3 req vec%0d", i), irq_req, VEC[i][3]);
            check($sformatf("R8 src vec%0d", i), irq_src, VEC[i][2:0]);
            check($sformatf("R10 save vec%0d", i), irq_save, VEC[i][3]);
            rd(2'd1, d);
            check($sformatf("R2 R5 R6 R7 pend vec%0d", i), d, DW'(VEC[i][10:4]));
        end

        // R2: a held level does not re-set a cleared bit
        wr(2'd1, '0);
        @(negedge clk); ext_irq1 = 1'b1;
        @(negedge clk);
        rd(2'd1, d); check("R2 first edge", d, 16'h0001);
        wr(2'd1, '0);
        @(negedge clk);
        rd(2'd1, d); check("R2 held level", d, 16'h0000);
        ext_irq1 = 1'b0;
        @(negedge clk);

        // R4: inside mode
        wr(2'd3, 16'h0001); wmode = 1'b1;
        wr(2'd1, '0);
        @(negedge clk); pix_wr = 1'b1; pix_in_win = 1'b0;
        @(negedge clk); pix_wr = 1'b0;
        @(negedge clk);
        rd(2'd1, d); check("R4 outside ignored", d, 16'h0000);
        pulse(7'h10);
        rd(2'd1, d); check("R4 inside flagged", d, 16'h0010);

        // R11: selective clear
        wr(2'd1, '0);
        pulse(7'h03);
        wr(2'd1, 16'h0002);
        rd(2'd1, d); check("R11 selective clear", d, 16'h0002);

        // R13: event and clear in the same cycle
        wr(2'd1, '0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = '0; ext_irq1 = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ext_irq1 = 1'b0;
        rd(2'd1, d); check("R13 event wins", d, 16'h0001);

        // R12: acknowledge of a maskable source leaves it pending
        wr(2'd1, '0);
        wr(2'd0, 16'h0004);
        pulse(7'h04);
        ack();
        check("R12 maskable ack req", irq_req, 1);
        check("R12 maskable ack src", irq_src, 2);

        // R9 R10: NMI over an enabled maskable source, state save requested
        nmi_pulse(1'b0);
        check("R9 nmi src", irq_src, 7);
        check("R10 nmi save", irq_save, 1);
        ack();
        check("R12 nmi cleared", irq_src, 2);

        // R9: NMI ignores the enable bits; R10: no-save mode
        wr(2'd1, '0);
        wr(2'd0, '0);
        nmi_pulse(1'b1);
        check("R9 nmi unmasked req", irq_req, 1);
        check("R9 nmi unmasked src", irq_src, 7);
        check("R10 nmi nosave", irq_save, 0);
        ack();
        check("R12 nmi ack req", irq_req, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule